// File: doc/BRIEF.md
# DMA stream FIFO controller

This block is the per-stream data buffer that sits between the read side and the write side of one DMA stream. It holds sixteen bytes, four 32-bit words, as a byte ring. It decides cycle by cycle whether the stream should fetch from its source or write to its destination. That decision depends on three settings: the transfer direction, a selectable fill threshold, and whether the stream runs in buffered or direct mode.

The source and destination sides each use a request/acknowledge pair. The controller raises a request when the policy allows a move. A byte move happens in any cycle where the request and its acknowledge are both high. The amount moved is the item width of that side (1, 2 or 4 bytes), taken from the low bytes of the data bus. Because the fill level is counted in bytes, a narrow source can be packed into a wide destination, and a wide source can be unpacked into a narrow one. Dropping the stream enable flushes everything.

Top module: `dma_stream_fifo`

## Requirements
- R1: `level_o` reports the number of stored bytes, from 0 to 16, and starts at 0 after reset. While enabled, each clock adds the bytes pushed and subtracts the bytes popped. Push width is 1, 2 or 4 bytes for size code 0, 1 or 2/3 of `src_size_i`; pop width follows `dst_size_o` in the same way. `src_req_o` is never high when the push would take the level above 16.
- R2: `thr_sel_i` sets the threshold: 0 = 4 bytes, 1 = 8 bytes, 2 = 12 bytes, 3 = 16 bytes.
- R3: Peripheral-to-memory, buffered (`dir_i` = 0, `direct_i` = 0). `src_req_o` is high while a peripheral request is pending and a source item fits. Reaching the threshold or more starts a drain phase. In that phase `dst_req_o` stays high while at least one destination item is stored. The phase ends when fewer bytes than one destination item remain.
- R4: Memory-to-peripheral, buffered (`dir_i` = 1, `direct_i` = 0). After enable, the FIFO is filled until the next source item would not fit. `dst_req_o` is high while a peripheral request is pending and a destination item is stored. Once the level drops to the threshold or below, a complete refill starts.
- R5: Memory-to-memory (`dir_i` = 2 or 3). The FIFO is filled until the level reaches the threshold, then drained until less than one destination item remains, and this repeats. Source and destination requests are never high together, and `per_req_i` has no effect.
- R6: Direct peripheral-to-memory. `src_req_o` is high only when the FIFO is empty and a peripheral request is pending. A stored item is offered to the destination immediately.
- R7: Direct memory-to-peripheral. Exactly one source item is preloaded while the FIFO is empty. It is offered to the destination on the next peripheral request, and then the next item is preloaded.
- R8: Width conversion exists only in buffered mode. In direct mode with `dir_i` < 2, `dst_size_o` equals `src_size_i`. Otherwise it equals `dst_size_i`. For memory-to-memory, `direct_i` is ignored.
- R9: While `en_i` is low, both requests are low. One clock after `en_i` goes low the level is 0 and any pending peripheral request is discarded.
- R10: Bytes leave in the order they entered. `dst_data_o` carries the oldest stored byte in bits 7:0, with zeros above the popped width.
- R11: A one-cycle pulse on `per_req_i` is remembered until the transfer it asks for takes place.
- R12: No bytes move in a cycle where a request is high but its acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Stream enable; low flushes |
| dir_i | input | 2 | 0 peripheral-to-memory, 1 memory-to-peripheral, 2/3 memory-to-memory |
| direct_i | input | 1 | Direct (threshold bypass) mode |
| thr_sel_i | input | 2 | Threshold select |
| src_size_i | input | 2 | Source item width code |
| dst_size_i | input | 2 | Destination item width code |
| per_req_i | input | 1 | Peripheral request pulse |
| src_req_o | output | 1 | Source read request |
| src_ack_i | input | 1 | Source read accepted, data valid |
| src_data_i | input | 32 | Source data, low bytes used |
| dst_req_o | output | 1 | Destination write request |
| dst_ack_i | input | 1 | Destination write accepted |
| dst_size_o | output | 2 | Effective destination width code |
| dst_data_o | output | 32 | Destination data |
| level_o | output | 5 | Stored byte count |

## Verification
The hardest state to reach is the memory-to-peripheral refill boundary under unpacking. There the level must fall exactly onto the threshold while a narrow peripheral drains a wide source, and source stalls land just as the phase flips. To reach it, the stimulus sweeps every threshold against mismatched width pairs. It drives sparse, random peripheral pulses and drops acknowledges at random, so odd residues and stalled boundary crossings both occur. A behavioural queue model decides every request and data value each cycle. Enables are dropped while data is still stored, which exercises the flush.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam logic [1:0] DIR_P2M = 2'd0;
  localparam logic [1:0] DIR_M2P = 2'd1;

  typedef enum logic {PH_FILL = 1'b0, PH_DRAIN = 1'b1} phase_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dsf_store.sv
module dsf_store #(
  parameter int unsigned CAP_BYTES = 16,
  parameter int unsigned LANES     = 4,
  parameter int unsigned LVL_W     = 5,
  parameter int unsigned SZ_W      = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 push_i,
  input  logic [SZ_W-1:0]      push_n_i,
  input  logic [8*LANES-1:0]   push_data_i,
  input  logic                 pop_i,
  input  logic [SZ_W-1:0]      pop_n_i,
  output logic [LVL_W-1:0]     level_o,
  output logic [LVL_W-1:0]     level_nxt_o,
  output logic [8*LANES-1:0]   head_data_o
);
  localparam int unsigned IDX_W = $clog2(CAP_BYTES);

  logic [7:0]       mem_q [CAP_BYTES];
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] level_q;

  always_comb begin
    level_nxt_o = level_q;
    if (push_i) level_nxt_o = level_nxt_o + LVL_W'(push_n_i);
    if (pop_i)  level_nxt_o = level_nxt_o - LVL_W'(pop_n_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
      for (int b = 0; b < CAP_BYTES; b++) mem_q[b] <= 8'h00;
    end else if (flush_i) begin
      level_q <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
    end else begin
      level_q <= level_nxt_o;
      if (push_i) begin
        wr_q <= wr_q + IDX_W'(push_n_i);
        for (int l = 0; l < LANES; l++)
          if (push_n_i > SZ_W'(l)) mem_q[wr_q + IDX_W'(l)] <= push_data_i[8*l +: 8];
      end
      if (pop_i) rd_q <= rd_q + IDX_W'(pop_n_i);
    end
  end

  // oldest byte on lane 0, lanes beyond the pop width forced to zero
  for (genvar l = 0; l < LANES; l++) begin : g_head
    assign head_data_o[8*l +: 8] = (pop_n_i > SZ_W'(l)) ? mem_q[rd_q + IDX_W'(l)] : 8'h00;
  end

  assign level_o = level_q;
endmodule

// File: rtl/dsf_policy.sv
module dsf_policy
  import dsf_pkg::*;
#(
  parameter int unsigned CAP_BYTES = 16,
  parameter int unsigned LVL_W     = 5,
  parameter int unsigned SZ_W      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       dir_i,
  input  logic             direct_i,
  input  logic [1:0]       thr_sel_i,
  input  logic [1:0]       src_size_i,
  input  logic [1:0]       dst_size_i,
  input  logic             per_req_i,
  input  logic             src_ack_i,
  input  logic             dst_ack_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] level_nxt_i,
  output logic             src_req_o,
  output logic             dst_req_o,
  output logic             push_o,
  output logic             pop_o,
  output logic [SZ_W-1:0]  src_n_o,
  output logic [SZ_W-1:0]  dst_n_o,
  output logic [1:0]       dst_size_o
);
  localparam int unsigned QTR = CAP_BYTES / 4;
  localparam int unsigned EW  = LVL_W + 1;

  phase_e           ph_q, ph_d;
  logic             pend_q, pend_d;
  logic             is_p2m, is_m2p, direct_eff;
  logic             eff_per, room, avail, full_nxt, take;
  logic [LVL_W-1:0] thr_b;

  assign is_p2m     = (dir_i == DIR_P2M);
  assign is_m2p     = (dir_i == DIR_M2P);
  assign direct_eff = direct_i & ~dir_i[1];
  assign dst_size_o = direct_eff ? src_size_i : dst_size_i;
  assign src_n_o    = SZ_W'(size_bytes(src_size_i));
  assign dst_n_o    = SZ_W'(size_bytes(dst_size_o));
  assign eff_per    = per_req_i | pend_q;

  assign room     = (EW'(level_i) + EW'(src_n_o)) <= EW'(CAP_BYTES);
  assign avail    = level_i >= LVL_W'(dst_n_o);
  assign full_nxt = (EW'(level_nxt_i) + EW'(src_n_o)) > EW'(CAP_BYTES);

  always_comb begin
    case (thr_sel_i)
      2'd0:    thr_b = LVL_W'(QTR);
      2'd1:    thr_b = LVL_W'(2 * QTR);
      2'd2:    thr_b = LVL_W'(3 * QTR);
      default: thr_b = LVL_W'(CAP_BYTES);
    endcase
  end

  always_comb begin
    src_req_o = 1'b0;
    dst_req_o = 1'b0;
    if (en_i) begin
      if (direct_eff) begin
        if (is_p2m) begin
          src_req_o = eff_per && (level_i == '0);
          dst_req_o = avail;
        end else begin
          src_req_o = (level_i == '0);
          dst_req_o = eff_per && avail;
        end
      end else if (is_p2m) begin
        src_req_o = eff_per && room;
        dst_req_o = (ph_q == PH_DRAIN) && avail;
      end else if (is_m2p) begin
        src_req_o = (ph_q == PH_FILL) && room;
        dst_req_o = eff_per && avail;
      end else begin
        src_req_o = (ph_q == PH_FILL) && room;
        dst_req_o = (ph_q == PH_DRAIN) && avail;
      end
    end
  end

  assign push_o = src_req_o & src_ack_i;
  assign pop_o  = dst_req_o & dst_ack_i;

  always_comb begin
    ph_d = ph_q;
    if (!en_i || direct_eff) begin
      ph_d = PH_FILL;
    end else if (is_m2p) begin
      if (ph_q == PH_FILL && full_nxt)             ph_d = PH_DRAIN;
      else if (ph_q == PH_DRAIN && level_nxt_i <= thr_b) ph_d = PH_FILL;
    end else begin
      if (ph_q == PH_FILL && level_nxt_i >= thr_b) ph_d = PH_DRAIN;
      else if (ph_q == PH_DRAIN && level_nxt_i < LVL_W'(dst_n_o)) ph_d = PH_FILL;
    end
  end

  // the peripheral is served by a push when it is the source, by a pop otherwise
  assign take   = is_p2m ? push_o : pop_o;
  assign pend_d = (en_i && !dir_i[1]) ? (eff_per & ~take) : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_FILL;
      pend_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/dma_stream_fifo.sv
module dma_stream_fifo #(
  parameter int unsigned LANES       = 4,
  parameter int unsigned DEPTH_WORDS = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  logic [1:0]                     dir_i,
  input  logic                           direct_i,
  input  logic [1:0]                     thr_sel_i,
  input  logic [1:0]                     src_size_i,
  input  logic [1:0]                     dst_size_i,
  input  logic                           per_req_i,
  output logic                           src_req_o,
  input  logic                           src_ack_i,
  input  logic [8*LANES-1:0]             src_data_i,
  output logic                           dst_req_o,
  input  logic                           dst_ack_i,
  output logic [1:0]                     dst_size_o,
  output logic [8*LANES-1:0]             dst_data_o,
  output logic [$clog2(LANES*DEPTH_WORDS+1)-1:0] level_o
);
  localparam int unsigned CAP_BYTES = LANES * DEPTH_WORDS;
  localparam int unsigned LVL_W     = $clog2(CAP_BYTES + 1);
  localparam int unsigned SZ_W      = $clog2(LANES + 1);

  logic             push, pop;
  logic [SZ_W-1:0]  src_n, dst_n;
  logic [LVL_W-1:0] level_nxt;

  dsf_policy #(.CAP_BYTES(CAP_BYTES), .LVL_W(LVL_W), .SZ_W(SZ_W)) u_policy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .dir_i       (dir_i),
    .direct_i    (direct_i),
    .thr_sel_i   (thr_sel_i),
    .src_size_i  (src_size_i),
    .dst_size_i  (dst_size_i),
    .per_req_i   (per_req_i),
    .src_ack_i   (src_ack_i),
    .dst_ack_i   (dst_ack_i),
    .level_i     (level_o),
    .level_nxt_i (level_nxt),
    .src_req_o   (src_req_o),
    .dst_req_o   (dst_req_o),
    .push_o      (push),
    .pop_o       (pop),
    .src_n_o     (src_n),
    .dst_n_o     (dst_n),
    .dst_size_o  (dst_size_o)
  );

  dsf_store #(.CAP_BYTES(CAP_BYTES), .LANES(LANES), .LVL_W(LVL_W), .SZ_W(SZ_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (~en_i),
    .push_i      (push),
    .push_n_i    (src_n),
    .push_data_i (src_data_i),
    .pop_i       (pop),
    .pop_n_i     (dst_n),
    .level_o     (level_o),
    .level_nxt_o (level_nxt),
    .head_data_o (dst_data_o)
  );
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker
  import dsf_pkg::*;
#(
  parameter int unsigned CAP_BYTES = 16,
  parameter int unsigned LVL_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       dir_i,
  input logic             direct_i,
  input logic [1:0]       src_size_i,
  input logic             src_req_o,
  input logic             src_ack_i,
  input logic             dst_req_o,
  input logic             dst_ack_i,
  input logic [1:0]       dst_size_o,
  input logic [LVL_W-1:0] level_o
);
  int   add_b, sub_b, prev_level, prev_add, prev_sub;
  logic prev_en, seen_q, direct_act;

  assign add_b      = (src_req_o && src_ack_i) ? int'(size_bytes(src_size_i)) : 0;
  assign sub_b      = (dst_req_o && dst_ack_i) ? int'(size_bytes(dst_size_o)) : 0;
  assign direct_act = en_i && direct_i && !dir_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_level <= 0;
      prev_add   <= 0;
      prev_sub   <= 0;
      prev_en    <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      prev_level <= int'(level_o);
      prev_add   <= add_b;
      prev_sub   <= sub_b;
      prev_en    <= en_i;
      seen_q     <= 1'b1;
    end
  end

  assert_level_cap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(level_o) <= int'(CAP_BYTES));

  assert_no_overflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_req_o |-> (int'(level_o) + int'(size_bytes(src_size_i))) <= int'(CAP_BYTES));

  assert_level_track_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && prev_en && en_i) |-> int'(level_o) == prev_level + prev_add - prev_sub);

  assert_no_underflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_req_o |-> int'(level_o) >= int'(size_bytes(dst_size_o)));

  assert_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !prev_en) |-> level_o == '0);

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !(src_req_o || dst_req_o));

  assert_direct_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_act |-> dst_size_o == src_size_i);

  assert_direct_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_act |-> int'(level_o) <= int'(size_bytes(src_size_i)));

  assert_m2m_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dir_i[1]) |-> !(src_req_o && dst_req_o));
endmodule

bind dma_stream_fifo dsf_checker #(.CAP_BYTES(CAP_BYTES), .LVL_W(LVL_W)) u_dsf_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .dir_i      (dir_i),
  .direct_i   (direct_i),
  .src_size_i (src_size_i),
  .src_req_o  (src_req_o),
  .src_ack_i  (src_ack_i),
  .dst_req_o  (dst_req_o),
  .dst_ack_i  (dst_ack_i),
  .dst_size_o (dst_size_o),
  .level_o    (level_o)
);

// File: tb/tb_dma_stream_fifo.sv
module tb_dma_stream_fifo;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [1:0]  dir_i = 2'd0;
  logic        direct_i = 1'b0;
  logic [1:0]  thr_sel_i = 2'd0;
  logic [1:0]  src_size_i = 2'd2;
  logic [1:0]  dst_size_i = 2'd2;
  logic        per_req_i = 1'b0;
  logic        src_ack_i = 1'b0;
  logic [31:0] src_data_i = 32'h0;
  logic        dst_ack_i = 1'b0;
  logic        src_req_o, dst_req_o;
  logic [1:0]  dst_size_o;
  logic [31:0] dst_data_o;
  logic [4:0]  level_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_stream_fifo dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .dir_i(dir_i), .direct_i(direct_i),
    .thr_sel_i(thr_sel_i), .src_size_i(src_size_i), .dst_size_i(dst_size_i),
    .per_req_i(per_req_i), .src_req_o(src_req_o), .src_ack_i(src_ack_i),
    .src_data_i(src_data_i), .dst_req_o(dst_req_o), .dst_ack_i(dst_ack_i),
    .dst_size_o(dst_size_o), .dst_data_o(dst_data_o), .level_o(level_o)
  );

  // reference model state
  byte unsigned q[$];
  bit  draining = 0;
  bit  pending = 0;

  function automatic int nb(bit [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 2 : 4;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // compare outputs against the model, then advance the model across the next edge
  task automatic cycle();
    int lvl, ssz, dsz, thr, nl;
    bit dire, per, es, ed;
    bit [1:0] dcode;
    string tag;
    longint expd;
    #1;
    lvl  = q.size();
    dire = direct_i && !dir_i[1];
    dcode = dire ? src_size_i : dst_size_i;
    ssz  = nb(src_size_i);
    dsz  = nb(dcode);
    thr  = 4 * (int'(thr_sel_i) + 1);
    per  = per_req_i || pending;
    es = 0; ed = 0;
    if (!en_i) tag = "R9";
    else if (dire && dir_i == 0) begin
      tag = "R6 R11";
      es = per && lvl == 0; ed = lvl >= dsz;
    end else if (dire) begin
      tag = "R7 R11";
      es = lvl == 0; ed = per && lvl >= dsz;
    end else if (dir_i == 0) begin
      tag = "R3 R2 R11";
      es = per && lvl + ssz <= 16; ed = draining && lvl >= dsz;
    end else if (dir_i == 1) begin
      tag = "R4 R2 R11";
      es = !draining && lvl + ssz <= 16; ed = per && lvl >= dsz;
    end else begin
      tag = "R5 R2";
      es = !draining && lvl + ssz <= 16; ed = draining && lvl >= dsz;
    end
    chk("R1 R12", "level", level_o, lvl);
    chk(tag, "src_req", src_req_o, es);
    chk(tag, "dst_req", dst_req_o, ed);
    chk("R8", "dst_size", dst_size_o, dcode);
    if (ed) begin
      expd = 0;
      for (int k = 0; k < dsz; k++) expd |= longint'(q[k]) << (8 * k);
      chk("R10", "dst_data", dst_data_o, expd);
    end
    // advance
    if (!en_i) begin
      q.delete(); draining = 0; pending = 0;
    end else begin
      if (ed && dst_ack_i) for (int k = 0; k < dsz; k++) void'(q.pop_front());
      if (es && src_ack_i) for (int k = 0; k < ssz; k++) q.push_back(src_data_i[8*k +: 8]);
      nl = q.size();
      if (dir_i[1]) pending = 0;
      else pending = per && !((dir_i == 0) ? (es && src_ack_i) : (ed && dst_ack_i));
      if (dire) draining = 0;
      else if (dir_i == 1) begin
        if (!draining && nl + ssz > 16) draining = 1;
        else if (draining && nl <= thr) draining = 0;
      end else begin
        if (!draining && nl >= thr) draining = 1;
        else if (draining && nl < dsz) draining = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic run(bit [1:0] d, bit dm, bit [1:0] th, bit [1:0] ss, bit [1:0] ds,
                     int n, int per_pct, int ack_pct);
    en_i = 0; per_req_i = 0; src_ack_i = 0; dst_ack_i = 0;
    dir_i = d; direct_i = dm; thr_sel_i = th; src_size_i = ss; dst_size_i = ds;
    repeat (2) cycle();
    en_i = 1;
    for (int i = 0; i < n; i++) begin
      per_req_i  = ($urandom_range(99) < per_pct);
      src_ack_i  = ($urandom_range(99) < ack_pct);
      dst_ack_i  = ($urandom_range(99) < ack_pct);
      src_data_i = $urandom;
      cycle();
    end
    en_i = 0; per_req_i = 0;
    repeat (2) cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    #1;
    chk("R1", "reset level", level_o, 0);
    chk("R9", "reset src_req", src_req_o, 0);
    chk("R9", "reset dst_req", dst_req_o, 0);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // buffered peripheral-to-memory, each threshold and packing
    run(2'd0, 0, 2'd0, 2'd2, 2'd2, 300, 40, 85);
    run(2'd0, 0, 2'd1, 2'd0, 2'd2, 300, 60, 80);
    run(2'd0, 0, 2'd2, 2'd1, 2'd0, 300, 50, 90);
    run(2'd0, 0, 2'd3, 2'd2, 2'd1, 300, 50, 75);
    // buffered memory-to-peripheral, refill boundary with unpacking
    run(2'd1, 0, 2'd0, 2'd2, 2'd2, 300, 40, 85);
    run(2'd1, 0, 2'd1, 2'd1, 2'd0, 300, 50, 80);
    run(2'd1, 0, 2'd2, 2'd0, 2'd1, 300, 30, 70);
    run(2'd1, 0, 2'd3, 2'd2, 2'd1, 300, 50, 90);
    // memory-to-memory, direct ignored
    run(2'd2, 0, 2'd0, 2'd2, 2'd0, 300, 50, 80);
    run(2'd2, 1, 2'd1, 2'd2, 2'd0, 300, 50, 80);
    run(2'd3, 0, 2'd2, 2'd0, 2'd2, 300, 50, 85);
    // direct modes with a mismatched requested destination width
    run(2'd0, 1, 2'd2, 2'd1, 2'd2, 300, 40, 80);
    run(2'd1, 1, 2'd0, 2'd0, 2'd2, 300, 40, 80);
    run(2'd1, 1, 2'd3, 2'd2, 2'd0, 300, 30, 60);
    // long stalls with a rare peripheral pulse
    run(2'd1, 0, 2'd1, 2'd2, 2'd2, 300, 5, 30);
    run(2'd0, 0, 2'd0, 2'd1, 2'd1, 300, 5, 30);
    summary();
    $finish;
  end
endmodule